// File: doc/BRIEF.md
# CAN Bit-Timing Quantum Generator

This block turns a stored bit-timing word into the time base of a CAN bit. A clock prescaler cuts the system clock into time quanta. A phase counter steps each bit through one synchronisation quantum, then time segment 1, then time segment 2. It gives a one-cycle strobe for every quantum, a strobe at the sample point (the end of segment 1), and a strobe when the synchronisation quantum of a new bit completes.

The divider is ten bits wide. Six of those bits sit in the timing word and four sit in a separate extension register. Every field holds its value minus one. Software may write the two registers only while both the configuration-enable input and the init input are high. Init also stops the time base and holds it at the start of a bit. A resynchronisation request can stretch segment 1 or trim segment 2 by an amount bounded by the jump width. The change lasts for the bit in progress only.

Top module: `can_bit_timer`

## Requirements
- R1: After reset, the timing readback is 0x2301 and the extension readback is 0.
- R2: A write with `wr_sel`=0 (timing word) or `wr_sel`=1 (extension) changes the register only when `wr_en`, `cfg_en` and `init` are all high. Otherwise both registers keep their contents.
- R3: Timing word layout: bits [5:0] hold the low divider bits, [7:6] the jump width, [11:8] segment 1 and [14:12] segment 2. Bit 15 is not stored and reads 0. Extension bits [3:0] form divider bits 9:6. Every field holds its value minus one, so a quantum lasts 1 to 1024 clocks.
- R4: `tq_tick` is high for exactly one clock per quantum, and consecutive ticks are divider+1 clocks apart.
- R5: A bit is 1 sync quantum, then segment-1 field + 1 quanta, then segment-2 field + 1 quanta. `bit_start` pulses on the last clock of the sync quantum.
- R6: `sample_tick` pulses on the last clock of the final quantum of segment 1. Segment 2 follows it at once.
- R7: While `init` is high, no strobe fires, the prescaler is cleared and the phase returns to the sync quantum. After `init` falls, the first quantum lasts a full divider+1 clocks and ends with `bit_start`.
- R8: A segment-1 field of 0 is treated as 1, so segment 1 always lasts at least 2 quanta.
- R9: A lengthen request (`resync_shorten`=0) adds min(`resync_qty`, jump width + 1) quanta to segment 1. It is accepted only before segment 2 has begun.
- R10: A shorten request (`resync_shorten`=1) removes min(`resync_qty`, jump width + 1) quanta from segment 2. Segment 2 never drops below 1 quantum.
- R11: Only the first accepted request in a bit has an effect. The adjustment is dropped when the bit ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration enable; writes need it together with init |
| init | input | 1 | Holds the time base stopped at the start of a bit |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the timing word, 1 selects the extension |
| wr_data | input | 16 | Write data |
| resync_req | input | 1 | Resynchronisation request |
| resync_shorten | input | 1 | 1 trims segment 2, 0 stretches segment 1 |
| resync_qty | input | 4 | Requested phase correction in quanta |
| tq_tick | output | 1 | Last clock of each quantum |
| sample_tick | output | 1 | Sample-point strobe |
| bit_start | output | 1 | End of the sync quantum of a bit |
| timing_rd | output | 16 | Timing word readback |
| ext_rd | output | 4 | Extension readback |

## Verification
On every clock, the embedded properties check the following:
- A write that is not allowed leaves both registers unchanged.
- Ticks are spaced apart whenever the divider exceeds one.
- The sample strobe hands over to segment 2, and a bit start hands over to segment 1.
- Init parks the phase at the sync quantum.
- An adjustment never exceeds the jump bound, and segment 2 keeps at least one quantum.

The exact lengths of the quanta and bits, the field positions, the minimum for segment 1, the acceptance window for a resync request and the one-request-per-bit rule can only be shown by the bench. It measures the clock distances between the strobes for several timing words and request patterns.

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter logic [15:0] RST_TIMING = 16'h2301,
  parameter logic [3:0]  RST_EXT    = 4'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_en,
  input  logic        init,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [15:0] wr_data,
  input  logic        resync_req,
  input  logic        resync_shorten,
  input  logic [3:0]  resync_qty,
  output logic        tq_tick,
  output logic        sample_tick,
  output logic        bit_start,
  output logic [15:0] timing_rd,
  output logic [3:0]  ext_rd
);

  typedef enum logic [1:0] {PH_SYNC, PH_SEG1, PH_SEG2} phase_t;

  logic [14:0] timing_q;
  logic [3:0]  ext_q;
  logic [9:0]  div_q, div_cnt;
  logic [1:0]  sjw_f;
  logic [3:0]  seg1_f;
  logic [2:0]  seg2_f;
  phase_t      phase;
  logic [4:0]  qcnt;
  logic [2:0]  lng, shr, jump_max, amt, shr_cap;
  logic        adj_done;
  logic [5:0]  seg1_len, seg2_len;
  logic        cfg_ok, bit_end;

  assign cfg_ok   = wr_en && cfg_en && init;
  assign div_q    = {ext_q, timing_q[5:0]};
  assign sjw_f    = timing_q[7:6];
  assign seg1_f   = timing_q[11:8];
  assign seg2_f   = timing_q[14:12];
  assign jump_max = {1'b0, sjw_f} + 3'd1;
  assign amt      = (resync_qty > {1'b0, jump_max}) ? jump_max : resync_qty[2:0];
  assign shr_cap  = (amt > seg2_f) ? seg2_f : amt;

  assign seg1_len = {2'b00, (seg1_f == 4'd0) ? 4'd1 : seg1_f} + 6'd1 + {3'b000, lng};
  assign seg2_len = {3'b000, seg2_f} + 6'd1 - {3'b000, shr};

  assign tq_tick     = !init && (div_cnt == div_q);
  assign bit_start   = tq_tick && (phase == PH_SYNC);
  assign sample_tick = tq_tick && (phase == PH_SEG1) && ({1'b0, qcnt} == seg1_len - 6'd1);
  assign bit_end     = tq_tick && (phase == PH_SEG2) && ({1'b0, qcnt} + 6'd1 >= seg2_len);

  assign timing_rd = {1'b0, timing_q};
  assign ext_rd    = ext_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timing_q <= RST_TIMING[14:0];
      ext_q    <= RST_EXT;
    end else if (cfg_ok) begin
      if (wr_sel) ext_q    <= wr_data[3:0];
      else        timing_q <= wr_data[14:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 div_cnt <= '0;
    else if (init || tq_tick)   div_cnt <= '0;
    else                        div_cnt <= div_cnt + 10'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_SYNC;
      qcnt  <= '0;
    end else if (init) begin
      phase <= PH_SYNC;
      qcnt  <= '0;
    end else if (tq_tick) begin
      case (phase)
        PH_SYNC: begin
          phase <= PH_SEG1;
          qcnt  <= '0;
        end
        PH_SEG1: begin
          if ({1'b0, qcnt} == seg1_len - 6'd1) begin
            phase <= PH_SEG2;
            qcnt  <= '0;
          end else qcnt <= qcnt + 5'd1;
        end
        default: begin
          if (bit_end) begin
            phase <= PH_SYNC;
            qcnt  <= '0;
          end else qcnt <= qcnt + 5'd1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lng <= '0; shr <= '0; adj_done <= 1'b0;
    end else if (init || bit_end) begin
      lng <= '0; shr <= '0; adj_done <= 1'b0;
    end else if (resync_req && !adj_done) begin
      if (resync_shorten) begin
        shr      <= shr_cap;
        adj_done <= 1'b1;
      end else if (phase != PH_SEG2) begin
        lng      <= amt;
        adj_done <= 1'b1;
      end
    end
  end

  assert_write_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ok |=> ($stable(timing_q) && $stable(ext_q)));

  assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tq_tick && div_q != 10'd0) |=> !tq_tick);

  assert_bit_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start |=> (phase == PH_SEG1 && qcnt == 5'd0));

  assert_sample_seg2_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> (phase == PH_SEG2 && qcnt == 5'd0));

  assert_init_park_R7: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (phase == PH_SYNC && qcnt == 5'd0));

  assert_jump_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lng <= jump_max) && (shr <= jump_max));

  assert_seg2_floor_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seg2_len >= 6'd1);

endmodule

// File: tb/test_can_bit_timer.sv
`timescale 1ns/1ps
module test_can_bit_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_en = 1'b0, init = 1'b1, wr_en = 1'b0, wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic resync_req = 1'b0, resync_shorten = 1'b0;
  logic [3:0] resync_qty = '0;
  logic tq_tick, sample_tick, bit_start;
  logic [15:0] timing_rd;
  logic [3:0] ext_rd;
  int total = 0, bad = 0;

  can_bit_timer i_can_bit_timer (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .init(init),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .resync_req(resync_req), .resync_shorten(resync_shorten), .resync_qty(resync_qty),
    .tq_tick(tq_tick), .sample_tick(sample_tick), .bit_start(bit_start),
    .timing_rd(timing_rd), .ext_rd(ext_rd));

  always #10 clk = ~clk;

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int brp, input int sjw, input int s1, input int s2);
    mk = {1'b0, 3'(s2), 4'(s1), 2'(sjw), 6'(brp)};
  endfunction

  task automatic cfg(input logic [15:0] tw, input logic [3:0] ex);
    @(negedge clk); init = 1'b1; cfg_en = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_data = tw;
    @(negedge clk); wr_sel = 1'b1; wr_data = {12'h000, ex};
    @(negedge clk); wr_en = 1'b0; cfg_en = 1'b0;
    @(negedge clk); init = 1'b0;
  endtask

  task automatic measure(input int at_a, input bit sh_a, input int q_a,
                         input int at_b, input bit sh_b, input int q_b,
                         output int d1, output int dt);
    int n;
    n = 0;
    do begin @(negedge clk); n++; end while (!bit_start && n < 5000);
    n = 0; d1 = -1; dt = -1;
    while (n < 5000) begin
      if (n == at_a) begin resync_req = 1'b1; resync_shorten = sh_a; resync_qty = 4'(q_a); end
      else if (n == at_b) begin resync_req = 1'b1; resync_shorten = sh_b; resync_qty = 4'(q_b); end
      else resync_req = 1'b0;
      @(negedge clk); n++;
      if (sample_tick && d1 < 0) d1 = n;
      if (bit_start) begin dt = n; break; end
    end
    resync_req = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 timing reset", int'(timing_rd), 16'h2301);
    check("R1 ext reset", int'(ext_rd), 0);
    check("R7 no tick in init", int'(tq_tick), 0);
  endtask

  task automatic t_write_gate;
    @(negedge clk); init = 1'b1; cfg_en = 1'b0; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'h1234;
    @(negedge clk); wr_sel = 1'b1; wr_data = 16'h0005;
    @(negedge clk); wr_en = 1'b0;
    check("R2 blocked without cfg_en", int'(timing_rd), 16'h2301);
    check("R2 ext blocked without cfg_en", int'(ext_rd), 0);
    init = 1'b0; cfg_en = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'h1234;
    @(negedge clk); wr_en = 1'b0;
    check("R2 blocked without init", int'(timing_rd), 16'h2301);
    init = 1'b1; wr_en = 1'b1; wr_data = 16'h9234;
    @(negedge clk); wr_en = 1'b0; cfg_en = 1'b0;
    check("R2 R3 allowed write, bit 15 reads 0", int'(timing_rd), 16'h1234);
  endtask

  task automatic t_basic;
    int d1, dt;
    cfg(mk(2, 0, 4, 1), 4'h0);
    measure(-1, 0, 0, -1, 0, 0, d1, dt);
    check("R6 sample after 5 quanta of 3 clocks", d1, 15);
    check("R5 bit of 8 quanta of 3 clocks", dt, 24);
  endtask

  task automatic t_tick;
    int n;
    n = 0;
    do begin @(negedge clk); n++; end while (!tq_tick && n < 100);
    n = 0;
    do begin @(negedge clk); n++; end while (!tq_tick && n < 100);
    check("R4 tick spacing", n, 3);
  endtask

  task automatic t_ext;
    int d1, dt;
    cfg(mk(0, 0, 1, 0), 4'h1);
    measure(-1, 0, 0, -1, 0, 0, d1, dt);
    check("R3 extension divider sample", d1, 130);
    check("R3 extension divider bit", dt, 260);
  endtask

  task automatic t_init;
    int n, strobes;
    cfg(mk(2, 0, 4, 1), 4'h0);
    repeat (7) @(negedge clk);
    init = 1'b1; strobes = 0;
    repeat (10) begin
      @(negedge clk);
      strobes += int'(tq_tick) + int'(sample_tick) + int'(bit_start);
    end
    check("R7 no strobes in init", strobes, 0);
    init = 1'b0; n = 0;
    do begin @(negedge clk); n++; end while (!tq_tick && n < 100);
    check("R7 first quantum after init", n, 2);
    check("R7 first tick is bit start", int'(bit_start), 1);
  endtask

  task automatic t_min_seg1;
    int d1, dt;
    cfg(mk(0, 0, 0, 0), 4'h0);
    measure(-1, 0, 0, -1, 0, 0, d1, dt);
    check("R8 seg1 minimum sample", d1, 2);
    check("R8 seg1 minimum bit", dt, 4);
  endtask

  task automatic t_lengthen;
    int d1, dt;
    cfg(mk(0, 1, 3, 3), 4'h0);
    measure(0, 0, 5, -1, 0, 0, d1, dt);
    check("R9 lengthen clipped sample", d1, 6);
    check("R9 lengthen clipped bit", dt, 11);
    measure(-1, 0, 0, -1, 0, 0, d1, dt);
    check("R11 next bit restored", dt, 9);
    measure(5, 0, 2, -1, 0, 0, d1, dt);
    check("R9 lengthen in seg2 ignored sample", d1, 4);
    check("R9 lengthen in seg2 ignored bit", dt, 9);
  endtask

  task automatic t_shorten;
    int d1, dt;
    measure(0, 1, 1, -1, 0, 0, d1, dt);
    check("R10 shorten sample unchanged", d1, 4);
    check("R10 shorten by 1", dt, 8);
    measure(0, 1, 3, -1, 0, 0, d1, dt);
    check("R10 shorten clipped to jump", dt, 7);
    cfg(mk(0, 3, 3, 0), 4'h0);
    measure(0, 1, 4, -1, 0, 0, d1, dt);
    check("R10 seg2 floor of one quantum", dt, 6);
  endtask

  task automatic t_once;
    int d1, dt;
    cfg(mk(0, 3, 3, 3), 4'h0);
    measure(0, 0, 1, 1, 0, 3, d1, dt);
    check("R11 second request ignored sample", d1, 5);
    check("R11 second request ignored bit", dt, 10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_gate();
    t_basic();
    t_tick();
    t_ext();
    t_init();
    t_min_seg1();
    t_lengthen();
    t_shorten();
    t_once();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule